// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides which hardware thread the instruction fetch stage serves. Every cycle it looks at a small status code per thread and two occupancy counts per thread (instruction queue and load/store queue). It then offers up to `NUM_PICKS` grants, each a thread index with a valid flag. A static mode input selects the policy. The policies are a fixed single-thread choice, a rotating order in which the served thread moves to the back, and two occupancy policies that prefer the emptiest queue.

The rotating policy keeps a priority list of thread indices in registers. Grant slot k is decided on the list as already changed by the slots before it in the same cycle. The fetch stage confirms each grant with a take pulse, and only a confirmed rotating grant changes the list. Grants are combinational in the inputs and the registered list. A list change shows up in the cycle after the clock edge that records the take.

Top module: `fetch_thread_select`

## Requirements
- R1: A thread is eligible only when its 3-bit status code is 0 (running), 1 (idle) or 7 (line fill done). Codes 2 to 6 are ineligible: 2 squashing, 3 blocked, 4 trap wait, 5 waiting for a cache response, 6 waiting for a cache retry.
- R2: After reset the priority list holds the thread indices in ascending order, with thread 0 at the head.
- R3: In rotate mode (mode 1), a slot grants the first eligible thread found by scanning from the head of the list. When that grant is taken, the thread leaves its position and is placed at the tail. The threads behind it each move up one place.
- R4: In rotate mode and in the occupancy modes, a slot's valid flag is low when no thread is eligible.
- R5: With more than one thread configured, single mode (mode 0) grants thread 0 on every slot with valid high, whatever the status codes are.
- R6: With one thread configured, every slot grants thread 0 exactly when that thread is eligible, in every mode.
- R7: Mode 2 grants the eligible thread with the smallest instruction-queue count. Mode 3 grants the eligible thread with the smallest load/store-queue count. On equal counts the lower index wins, and ineligible threads are skipped.
- R8: The list changes only on a rotate-mode slot whose grant is valid and taken. Takes in other modes, and takes on an invalid slot, leave it unchanged.
- R9: Slot k sees the list as already rotated by every taken grant of slots 0 to k-1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Policy: 0 single, 1 rotate, 2 instruction-queue occupancy, 3 load/store-queue occupancy |
| thread_status_i | input | 3*NUM_THREADS | Status code of thread i in bits [3i+2:3i] |
| iq_count_i | input | CNT_W*NUM_THREADS | Instruction-queue count of thread i in bits [CNT_W*i +: CNT_W] |
| lsq_count_i | input | CNT_W*NUM_THREADS | Load/store-queue count of thread i, same packing |
| grant_take_i | input | NUM_PICKS | Fetch accepted slot k's grant in this cycle |
| grant_valid_o | output | NUM_PICKS | Slot k holds a grant |
| grant_tid_o | output | TID_W*NUM_PICKS | Thread index of slot k in bits [TID_W*k +: TID_W] |

## Verification
Each slot's grant depends only on the present inputs and the registered list, so the result is due in the same cycle as the stimulus. The only delayed effect is a list rotation from a take, which appears one clock edge later. The driver applies inputs on the falling edge and queues the expected grants, which it computes from a model list that it advances at that edge. The monitor compares them 2 ns later, well before the next rising edge. Because of this, a rotation is only ever observed in the cycle after the one that took the grant.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    typedef enum logic [2:0] {
        TS_RUN        = 3'd0,
        TS_IDLE       = 3'd1,
        TS_SQUASH     = 3'd2,
        TS_BLOCKED    = 3'd3,
        TS_TRAP       = 3'd4,
        TS_WAIT_RESP  = 3'd5,
        TS_WAIT_RETRY = 3'd6,
        TS_FILL_DONE  = 3'd7
    } tstat_e;

    typedef enum logic [1:0] {
        SEL_SINGLE = 2'd0,
        SEL_ROTATE = 2'd1,
        SEL_IQ     = 2'd2,
        SEL_LSQ    = 2'd3
    } selmode_e;

    localparam int STAT_W = 3;

    // R1: threads that may be handed to fetch
    function automatic logic can_fetch(input logic [STAT_W-1:0] s);
        return (s == TS_RUN) || (s == TS_IDLE) || (s == TS_FILL_DONE);
    endfunction

endpackage

// File: rtl/fsel_rr_pick.sv
module fsel_rr_pick #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input  logic [N-1:0][TID_W-1:0] order_i,
    input  logic [N-1:0]            elig_i,
    output logic                    found_o,
    output logic [TID_W-1:0]        tid_o,
    output logic [N-1:0][TID_W-1:0] order_o
);
    int pos;

    always_comb begin
        found_o = 1'b0;
        pos     = 0;
        for (int i = 0; i < N; i++) begin
            if (!found_o && elig_i[order_i[i]]) begin
                found_o = 1'b1;
                pos     = i;
            end
        end
        tid_o = order_i[pos];
        // move-to-back: entries behind the winner shift toward the head
        for (int i = 0; i < N - 1; i++) begin
            order_o[i] = (i < pos) ? order_i[i] : order_i[i+1];
        end
        order_o[N-1] = tid_o;
    end
endmodule

// File: rtl/fsel_occ_pick.sv
module fsel_occ_pick #(
    parameter int N     = 4,
    parameter int CNT_W = 6,
    parameter int TID_W = 2
) (
    input  logic [N-1:0][CNT_W-1:0] counts_i,
    input  logic [N-1:0]            elig_i,
    output logic                    valid_o,
    output logic [TID_W-1:0]        tid_o
);
    logic [CNT_W-1:0] best;

    always_comb begin
        valid_o = 1'b0;
        tid_o   = '0;
        best    = '0;
        // strict compare keeps the lower index on ties
        for (int i = 0; i < N; i++) begin
            if (elig_i[i] && (!valid_o || counts_i[i] < best)) begin
                valid_o = 1'b1;
                best    = counts_i[i];
                tid_o   = TID_W'(i);
            end
        end
    end
endmodule

// File: rtl/fetch_thread_select.sv
module fetch_thread_select
    import fsel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int NUM_PICKS   = 2,
    parameter int CNT_W       = 6,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     mode_i,
    input  logic [STAT_W*NUM_THREADS-1:0]  thread_status_i,
    input  logic [CNT_W*NUM_THREADS-1:0]   iq_count_i,
    input  logic [CNT_W*NUM_THREADS-1:0]   lsq_count_i,
    input  logic [NUM_PICKS-1:0]           grant_take_i,
    output logic [NUM_PICKS-1:0]           grant_valid_o,
    output logic [TID_W*NUM_PICKS-1:0]     grant_tid_o
);
    typedef logic [NUM_THREADS-1:0][TID_W-1:0] order_t;
    typedef struct packed {
        order_t order;
    } state_t;

    state_t st_q, st_d;

    logic [NUM_THREADS-1:0]            elig;
    logic [NUM_THREADS-1:0][CNT_W-1:0] iq_cnt, lsq_cnt;
    logic                              iq_valid, lsq_valid;
    logic [TID_W-1:0]                  iq_tid, lsq_tid;
    order_t                            stage [NUM_PICKS+1];

    assign iq_cnt  = iq_count_i;
    assign lsq_cnt = lsq_count_i;

    always_comb begin
        for (int i = 0; i < NUM_THREADS; i++) begin
            elig[i] = can_fetch(thread_status_i[i*STAT_W +: STAT_W]);
        end
    end

    fsel_occ_pick #(.N(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) u_occ_iq (
        .counts_i(iq_cnt), .elig_i(elig), .valid_o(iq_valid), .tid_o(iq_tid)
    );
    fsel_occ_pick #(.N(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) u_occ_lsq (
        .counts_i(lsq_cnt), .elig_i(elig), .valid_o(lsq_valid), .tid_o(lsq_tid)
    );

    assign stage[0] = st_q.order;

    for (genvar k = 0; k < NUM_PICKS; k++) begin : g_pick
        logic             rr_found;
        logic [TID_W-1:0] rr_tid;
        order_t           rr_rot;
        logic             v;
        logic [TID_W-1:0] t;

        fsel_rr_pick #(.N(NUM_THREADS), .TID_W(TID_W)) u_rr (
            .order_i(stage[k]), .elig_i(elig),
            .found_o(rr_found), .tid_o(rr_tid), .order_o(rr_rot)
        );

        // R9: the next slot sees this slot's rotation
        assign stage[k+1] = (mode_i == SEL_ROTATE && rr_found && grant_take_i[k])
                            ? rr_rot : stage[k];

        if (NUM_THREADS == 1) begin : g_solo
            always_comb begin
                v = elig[0];
                t = '0;
            end
        end else begin : g_multi
            always_comb begin
                case (selmode_e'(mode_i))
                    SEL_SINGLE: begin v = 1'b1;      t = '0;      end
                    SEL_ROTATE: begin v = rr_found;  t = rr_tid;  end
                    SEL_IQ:     begin v = iq_valid;  t = iq_tid;  end
                    SEL_LSQ:    begin v = lsq_valid; t = lsq_tid; end
                    default:    begin v = 1'b0;      t = '0;      end
                endcase
            end
        end

        assign grant_valid_o[k]             = v;
        assign grant_tid_o[k*TID_W +: TID_W] = t;

        assert_grant_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ((NUM_THREADS == 1 || mode_i != SEL_SINGLE) && grant_valid_o[k])
            |-> elig[grant_tid_o[k*TID_W +: TID_W]]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.order = stage[NUM_PICKS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_THREADS; i++) st_q.order[i] <= TID_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- assertions ----------------
    logic [NUM_THREADS-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < NUM_THREADS; i++) seen[st_q.order[i]] = 1'b1;
    end

    assert_list_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        &seen);

    assert_tail_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SEL_ROTATE && grant_valid_o[0] && grant_take_i == NUM_PICKS'(1))
        |=> st_q.order[NUM_THREADS-1] == $past(grant_tid_o[TID_W-1:0]));

    assert_no_elig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0 && (NUM_THREADS == 1 || mode_i != SEL_SINGLE)) |-> !grant_valid_o[0]);

    assert_list_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != SEL_ROTATE || (grant_take_i & grant_valid_o) == '0)
        |=> st_q.order == $past(st_q.order));

    if (NUM_THREADS > 1) begin : g_single_chk
        assert_single_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == SEL_SINGLE) |-> (grant_valid_o[0] && grant_tid_o[TID_W-1:0] == '0));
    end

    logic occ_ok;
    always_comb begin
        logic [NUM_THREADS-1:0][CNT_W-1:0] c;
        logic [TID_W-1:0] g;
        c      = (mode_i == SEL_LSQ) ? lsq_cnt : iq_cnt;
        g      = grant_tid_o[TID_W-1:0];
        occ_ok = 1'b1;
        for (int i = 0; i < NUM_THREADS; i++) begin
            if (elig[i] && (c[i] < c[g] || (c[i] == c[g] && i < int'(g)))) occ_ok = 1'b0;
        end
    end

    assert_occ_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_THREADS > 1 && (mode_i == SEL_IQ || mode_i == SEL_LSQ) && grant_valid_o[0])
        |-> occ_ok);

endmodule

// File: tb/fetch_thread_select_tb.sv
module fetch_thread_select_tb;
    localparam int N = 4;
    localparam int P = 2;
    localparam int W = 6;

    typedef struct {
        int    slot;
        bit    valid;
        int    tid;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode = 2'd1;
    logic [3*N-1:0]   status = '0;
    logic [W*N-1:0]   iq = '0;
    logic [W*N-1:0]   lsq = '0;
    logic [P-1:0]     take = '0;
    logic [P-1:0]     gv;
    logic [2*P-1:0]   gt;

    logic [2:0]       solo_st = 3'd0;
    logic [0:0]       solo_take = 1'b0;
    logic [0:0]       solo_v;
    logic [0:0]       solo_t;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int mdl [N];
    exp_t q [$];

    always #5 clk = ~clk;

    fetch_thread_select #(.NUM_THREADS(N), .NUM_PICKS(P), .CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .thread_status_i(status),
        .iq_count_i(iq), .lsq_count_i(lsq), .grant_take_i(take),
        .grant_valid_o(gv), .grant_tid_o(gt)
    );

    fetch_thread_select #(.NUM_THREADS(1), .NUM_PICKS(1), .CNT_W(W)) u_solo (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .thread_status_i(solo_st),
        .iq_count_i(iq[W-1:0]), .lsq_count_i(lsq[W-1:0]), .grant_take_i(solo_take),
        .grant_valid_o(solo_v), .grant_tid_o(solo_t)
    );

    function automatic bit ok(input logic [2:0] s);
        return s == 3'd0 || s == 3'd1 || s == 3'd7;
    endfunction

    function automatic logic [3*N-1:0] st4(input int a, b, c, d);
        return {3'(d), 3'(c), 3'(b), 3'(a)};
    endfunction

    function automatic logic [W*N-1:0] cn4(input int a, b, c, d);
        return {W'(d), W'(c), W'(b), W'(a)};
    endfunction

    task automatic drive(input int m, input logic [3*N-1:0] s, input logic [W*N-1:0] ci,
                         input logic [W*N-1:0] cl, input logic [P-1:0] tk,
                         input logic [2:0] ss, input string req);
        exp_t e;
        @(negedge clk);
        mode = 2'(m); status = s; iq = ci; lsq = cl; take = tk;
        solo_st = ss; solo_take = tk[0];
        for (int k = 0; k < P; k++) begin
            bit v; int t; int pos;
            v = 0; t = 0; pos = 0;
            if (m == 0) begin
                v = 1; t = 0;
            end else if (m == 1) begin
                for (int i = 0; i < N; i++)
                    if (!v && ok(s[mdl[i]*3 +: 3])) begin v = 1; pos = i; t = mdl[i]; end
                if (v && tk[k]) begin
                    for (int i = pos; i < N - 1; i++) mdl[i] = mdl[i+1];
                    mdl[N-1] = t;
                end
            end else begin
                logic [W*N-1:0] c;
                int best;
                c = (m == 2) ? ci : cl;
                best = 0;
                for (int i = 0; i < N; i++)
                    if (ok(s[i*3 +: 3]) && (!v || int'(c[i*W +: W]) < best)) begin
                        v = 1; t = i; best = int'(c[i*W +: W]);
                    end
            end
            e.slot = k; e.valid = v; e.tid = t; e.req = req;
            q.push_back(e);
        end
        e.slot = -1; e.valid = ok(ss); e.tid = 0; e.req = "R6";
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                bit av; int at;
                e = q.pop_front();
                if (e.slot < 0) begin av = solo_v[0]; at = int'(solo_t); end
                else begin av = gv[e.slot]; at = int'(gt[e.slot*2 +: 2]); end
                checks++;
                if (av !== e.valid || (e.valid && at != e.tid)) begin
                    errors++;
                    $display("FAIL %s slot %0d: actual valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                             e.req, e.slot, av, at, e.valid, e.tid);
                end
            end
        end
    end

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [3*N-1:0] run;
        logic [W*N-1:0] z;
        run = st4(0, 0, 0, 0);
        z = '0;
        for (int i = 0; i < N; i++) mdl[i] = i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: ascending order after reset
        drive(1, run, z, z, 2'b00, 3'd0, "R2");
        // R3: single take per cycle walks through the threads
        for (int n = 0; n < 5; n++) drive(1, run, z, z, 2'b01, 3'd1, "R3");
        // R9: two takes per cycle
        for (int n = 0; n < 3; n++) drive(1, run, z, z, 2'b11, 3'd7, "R9");
        // R1: mixed status codes
        for (int n = 0; n < 3; n++) drive(1, st4(3, 1, 5, 7), z, z, 2'b01, 3'd3, "R1");
        drive(1, st4(2, 4, 6, 0), z, z, 2'b11, 3'd5, "R1");
        // R4 and R8: nothing eligible, takes ignored
        drive(1, st4(2, 3, 5, 6), z, z, 2'b11, 3'd6, "R4");
        drive(1, run, z, z, 2'b00, 3'd0, "R8");
        // R5: single mode ignores status; R8 list kept
        drive(0, st4(3, 3, 0, 0), z, z, 2'b11, 3'd3, "R5");
        drive(1, run, z, z, 2'b00, 3'd1, "R8");
        // R7: occupancy policies
        drive(2, run, cn4(5, 2, 9, 2), cn4(0, 0, 0, 0), 2'b11, 3'd0, "R7");
        drive(2, st4(0, 3, 0, 0), cn4(5, 2, 9, 2), z, 2'b00, 3'd2, "R7");
        drive(3, run, cn4(5, 2, 9, 2), cn4(1, 8, 0, 4), 2'b00, 3'd7, "R7");
        drive(3, st4(0, 0, 5, 0), z, cn4(1, 8, 0, 4), 2'b01, 3'd4, "R7");
        drive(3, run, z, cn4(3, 3, 3, 3), 2'b00, 3'd1, "R7");
        drive(2, st4(4, 4, 4, 4), cn4(1, 1, 1, 1), z, 2'b11, 3'd6, "R4");
        drive(1, run, z, z, 2'b01, 3'd0, "R8");
        drive(1, run, z, z, 2'b10, 3'd0, "R9");

        @(negedge clk);
        take = '0;
        solo_take = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule